// File: doc/BRIEF.md
# Always-on domain shutdown sequencer

This block walks a subsystem's always-on control domain down to reset once a shutdown is commanded. After a start command it first asks an external halt handshake block to quiesce the subsystem's bus port and waits for that block to report completion. It then edits a configuration word one field per clock cycle. First the domain-enable bit is set. Next the bus-enable bit is set and the bus mux select field is zeroed. Finally an extra control bit is set.

With the configuration in place, the sequencer polls a 16-bit status input at a fixed interval until it reads the value 0x0400. If the poll budget runs out, it raises an error and returns to idle. On a match it asserts the always-on reset, clears the domain-enable bit, then asserts the subsystem reset and pulses done. The configuration word is held in the block and driven out continuously. Bits that the sequence does not name keep their value.

Top module: `aon_shutdown_seq`

## Requirements
- R1: After reset, `cfg_o` equals the parameter `CFG_RST` (default 0x00070A04), and `halt_req_o`, `aon_rst_o`, `sys_rst_o`, `done_o` and `err_o` are all 0.
- R2: A start accepted in idle raises `halt_req_o` from the next cycle. `halt_req_o` stays high, and `cfg_o` stays unchanged, until `halt_done_i` is sampled high.
- R3: Starting the cycle after the halt completes, `cfg_o` changes once per cycle in three steps. Step one sets bit 13. Step two sets bit 15 and clears bits 18:16. Step three sets bit 1. Every other bit keeps its value.
- R4: The low 16 bits of status, `status_i`, are compared with `STAT_MATCH` (0x0400) once every `POLL_INTERVAL` cycles. The first comparison happens `POLL_INTERVAL` cycles after bit 1 is set. Any other value counts as a miss.
- R5: After `MAX_POLLS` misses in a row, `err_o` is set and the block returns to idle. Neither reset output is asserted, and bit 13 is left set.
- R6: On a match, `aon_rst_o` rises on the next cycle. Bit 13 of `cfg_o` clears one cycle after that, and `sys_rst_o` rises one cycle later still.
- R7: `done_o` is high for exactly one cycle, in the same cycle that `sys_rst_o` rises. `aon_rst_o`, `sys_rst_o` and `err_o` hold their value until the next accepted start, which clears them.
- R8: A start while a sequence is running is ignored and does not change the sequence's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Shutdown command, sampled in idle |
| halt_req_o | output | 1 | Bus halt request to the external handshake block |
| halt_done_i | input | 1 | Halt handshake completed |
| status_i | input | 16 | Low 16 bits of the domain status word |
| cfg_o | output | CFG_W | Configuration word |
| aon_rst_o | output | 1 | Always-on domain reset |
| sys_rst_o | output | 1 | Subsystem reset |
| done_o | output | 1 | One-cycle pulse on success |
| err_o | output | 1 | Poll budget exhausted |

## Verification
Let edge 1 be the edge that samples start and H the number of cycles until the halt completes. Then bit 13 sets at edge H+2 and bit 1 at edge H+4. Poll p is taken at edge H+4+p·I, where I is the poll interval. A match on poll P gives the always-on reset at edge H+5+P·I, the bit 13 clear one edge later, and the subsystem reset with done one edge after that. A timeout shows as the error at edge H+4+MAX·I. The bench counts rising edges from edge 1 and samples every output at the falling edge after each rising edge. It records the edge at which each event first appears and compares that edge with these formulas, and it checks the configuration word edge by edge.

// File: rtl/aon_seq_pkg.sv
package aon_seq_pkg;
  localparam int EN_BIT  = 13;
  localparam int BUS_BIT = 15;
  localparam int CTL_BIT = 1;
  localparam int MUX_LSB = 16;
  localparam int MUX_W   = 3;

  typedef enum logic [2:0] {
    OP_HOLD, OP_SET_EN, OP_BUS, OP_SET_CTL, OP_CLR_EN
  } cfg_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_HALT, S_EN, S_BUS, S_CTL, S_POLL, S_AON, S_CLR, S_SYS
  } seq_state_e;
endpackage

// File: rtl/aon_poll_timer.sv
module aon_poll_timer #(
  parameter int INTERVAL  = 250000,
  parameter int MAX_POLLS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o,
  output logic last_o
);
  localparam int IW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam int PW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [IW-1:0] IV_LAST  = IW'(INTERVAL - 1);
  localparam logic [PW-1:0] CNT_LAST = PW'(MAX_POLLS - 1);

  logic [IW-1:0] ivl_q, ivl_n;
  logic [PW-1:0] cnt_q, cnt_n;

  assign tick_o = en_i && (ivl_q == IV_LAST);
  assign last_o = (cnt_q == CNT_LAST);

  always_comb begin
    ivl_n = ivl_q;
    cnt_n = cnt_q;
    if (clr_i) begin
      ivl_n = '0;
      cnt_n = '0;
    end else if (en_i) begin
      if (tick_o) begin
        ivl_n = '0;
        if (!last_o) cnt_n = cnt_q + 1'b1;
      end else begin
        ivl_n = ivl_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q <= '0;
      cnt_q <= '0;
    end else begin
      ivl_q <= ivl_n;
      cnt_q <= cnt_n;
    end
  end

  // R5
  poll_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);
endmodule

// File: rtl/aon_cfg_word.sv
module aon_cfg_word
  import aon_seq_pkg::*;
#(
  parameter int          CFG_W   = 32,
  parameter logic [31:0] CFG_RST = 32'h0007_0A04
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_op_e          op_i,
  output logic [CFG_W-1:0] cfg_o
);
  logic [CFG_W-1:0] q, n;

  always_comb begin
    n = q;
    case (op_i)
      OP_SET_EN:  n[EN_BIT] = 1'b1;
      OP_BUS: begin
        n[BUS_BIT] = 1'b1;
        n[MUX_LSB +: MUX_W] = '0;
      end
      OP_SET_CTL: n[CTL_BIT] = 1'b1;
      OP_CLR_EN:  n[EN_BIT] = 1'b0;
      default:    n = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= CFG_W'(CFG_RST);
    else        q <= n;
  end

  assign cfg_o = q;

  // R3
  ctl_after_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q[CTL_BIT]) |-> (q[BUS_BIT] && (q[MUX_LSB +: MUX_W] == '0)));
endmodule

// File: rtl/aon_shutdown_seq.sv
module aon_shutdown_seq
  import aon_seq_pkg::*;
#(
  parameter int          CFG_W         = 32,
  parameter logic [31:0] CFG_RST       = 32'h0007_0A04,
  parameter logic [15:0] STAT_MATCH    = 16'h0400,
  parameter int          POLL_INTERVAL = 250000,
  parameter int          MAX_POLLS     = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             halt_req_o,
  input  logic             halt_done_i,
  input  logic [15:0]      status_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             aon_rst_o,
  output logic             sys_rst_o,
  output logic             done_o,
  output logic             err_o
);
  seq_state_e st_q, st_n;
  cfg_op_e    op;
  logic       tick, last, match;
  logic       aon_q, aon_n, sys_q, sys_n, done_q, done_n, err_q, err_n;
  logic       accept;

  assign match  = (status_i == STAT_MATCH);
  assign accept = (st_q == S_IDLE) && start_i;

  aon_poll_timer #(.INTERVAL(POLL_INTERVAL), .MAX_POLLS(MAX_POLLS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (st_q != S_POLL),
    .en_i   (st_q == S_POLL),
    .tick_o (tick),
    .last_o (last)
  );

  aon_cfg_word #(.CFG_W(CFG_W), .CFG_RST(CFG_RST)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .op_i  (op),
    .cfg_o (cfg_o)
  );

  always_comb begin
    st_n   = st_q;
    op     = OP_HOLD;
    aon_n  = aon_q;
    sys_n  = sys_q;
    err_n  = err_q;
    done_n = 1'b0;
    case (st_q)
      S_IDLE: if (start_i) begin
        st_n  = S_HALT;
        aon_n = 1'b0;
        sys_n = 1'b0;
        err_n = 1'b0;
      end
      S_HALT: if (halt_done_i) st_n = S_EN;
      S_EN:  begin op = OP_SET_EN;  st_n = S_BUS;  end
      S_BUS: begin op = OP_BUS;     st_n = S_CTL;  end
      S_CTL: begin op = OP_SET_CTL; st_n = S_POLL; end
      S_POLL: if (tick) begin
        if (match) st_n = S_AON;
        else if (last) begin
          st_n  = S_IDLE;
          err_n = 1'b1;
        end
      end
      S_AON: begin aon_n = 1'b1; st_n = S_CLR; end
      S_CLR: begin op = OP_CLR_EN; st_n = S_SYS; end
      S_SYS: begin
        sys_n  = 1'b1;
        done_n = 1'b1;
        st_n   = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      aon_q  <= 1'b0;
      sys_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      aon_q  <= aon_n;
      sys_q  <= sys_n;
      done_q <= done_n;
      err_q  <= err_n;
    end
  end

  assign halt_req_o = (st_q == S_HALT);
  assign aon_rst_o  = aon_q;
  assign sys_rst_o  = sys_q;
  assign done_o     = done_q;
  assign err_o      = err_q;

  // R2
  halt_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req_o && !halt_done_i) |=> $stable(cfg_o));
  // R6
  en_clear_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_o[EN_BIT]) |-> aon_rst_o);
  // R6
  sys_after_aon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> aon_rst_o);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R5
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));
  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !accept && !halt_req_o && !done_o) |=> !halt_req_o);
endmodule

// File: tb/tb_aon_shutdown_seq.sv
module tb_aon_shutdown_seq;
  localparam int IV  = 4;
  localparam int MXP = 5;
  localparam logic [31:0] CRST  = 32'h0007_0A04;
  localparam logic [31:0] C_EN  = CRST | 32'h0000_2000;
  localparam logic [31:0] C_BUS = (C_EN | 32'h0000_8000) & ~32'h0007_0000;
  localparam logic [31:0] C_CTL = C_BUS | 32'h0000_0002;
  localparam logic [31:0] C_DONE = C_CTL & ~32'h0000_2000;

  logic clk, rst_n, start, halt_req, halt_done, aon, sys, done, err;
  logic [15:0] status;
  logic [31:0] cfg;
  int checks = 0, errors = 0;

  aon_shutdown_seq #(.POLL_INTERVAL(IV), .MAX_POLLS(MXP)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .halt_req_o(halt_req),
    .halt_done_i(halt_done), .status_i(status), .cfg_o(cfg),
    .aon_rst_o(aon), .sys_rst_o(sys), .done_o(done), .err_o(err));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; halt_done = 1'b0; status = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  int n_end, t_aon, t_clr, t_sys;
  logic got_done, got_err, r1_aon, r1_sys, r1_err, halt1, halt_w;
  logic [31:0] cfg_w;
  logic [31:0] hist [0:15];

  task automatic run_seq(input int hd, input logic [15:0] st0, input logic [15:0] st1,
                         input int k, input bit poke);
    int n;
    logic prev_en;
    t_aon = 0; t_clr = 0; t_sys = 0;
    foreach (hist[i]) hist[i] = '0;
    @(negedge clk); start = 1'b1; status = st0; halt_done = 1'b0;
    @(negedge clk); start = 1'b0; n = 1;
    halt1 = halt_req; r1_aon = aon; r1_sys = sys; r1_err = err;
    hist[1] = cfg; cfg_w = cfg; halt_w = halt_req;
    prev_en = cfg[13];
    halt_done = (n >= hd);
    while (!done && !err && n < 400) begin
      @(negedge clk); n++;
      if (n < 16) hist[n] = cfg;
      if (n == hd) begin cfg_w = cfg; halt_w = halt_req; end
      halt_done = (n >= hd);
      if (k > 0 && n == 4 + hd + k * IV) status = st1;
      start = (poke && n == hd + 6);
      if (aon && t_aon == 0) t_aon = n;
      if (prev_en && !cfg[13] && t_clr == 0) t_clr = n;
      prev_en = cfg[13];
      if (sys && t_sys == 0) t_sys = n;
    end
    n_end = n; got_done = done; got_err = err;
    halt_done = 1'b0; start = 1'b0;
  endtask

  localparam logic [16:0] VEC [6] = '{17'h1_0400, 17'h0_0401, 17'h0_0000,
                                     17'h0_C400, 17'h0_0500, 17'h0_FBFF};

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk("R1 cfg", cfg, CRST);
    chk("R1 outputs", {halt_req, aon, sys, done, err}, 5'b0);

    foreach (VEC[v]) begin
      do_reset();
      run_seq(1, VEC[v][15:0], VEC[v][15:0], 0, 0);
      if (VEC[v][16]) begin
        // R4 match on first poll, R6 ordering, R7 done with sys
        chk("R4 done cycle", n_end, 8 + IV);
        chk("R7 done/err", {got_done, got_err}, 2'b10);
        chk("R6 aon edge", t_aon, 6 + IV);
        chk("R6 clr edge", t_clr, 7 + IV);
        chk("R6 sys edge", t_sys, 8 + IV);
        chk("R3 final cfg", cfg, C_DONE);
        // R3 one step per cycle
        chk("R3 step0", hist[2], CRST);
        chk("R3 step1", hist[3], C_EN);
        chk("R3 step2", hist[4], C_BUS);
        chk("R3 step3", hist[5], C_CTL);
        chk("R2 halt req", halt1, 1'b1);
        @(negedge clk);
        chk("R7 done one cycle", {done, aon, sys}, 3'b011);
      end else begin
        // R5 timeout on mismatch
        chk("R5 err cycle", n_end, 5 + MXP * IV);
        chk("R5 done/err", {got_done, got_err}, 2'b01);
        chk("R5 no resets", {aon, sys}, 2'b00);
        chk("R5 cfg", cfg, C_CTL);
      end
    end

    // R2 halt wait stalls the sequence
    do_reset();
    run_seq(4, 16'h0400, 16'h0400, 0, 0);
    chk("R2 stall cfg", cfg_w, CRST);
    chk("R2 stall halt req", halt_w, 1'b1);
    chk("R2 done cycle", n_end, 11 + IV);

    // R4 match on a later poll
    do_reset();
    run_seq(1, 16'h0000, 16'h0400, 2, 0);
    chk("R4 third poll", n_end, 8 + 3 * IV);
    chk("R4 done", got_done, 1'b1);
    // R4/R5 match on the last allowed poll
    do_reset();
    run_seq(1, 16'h0401, 16'h0400, MXP - 1, 0);
    chk("R5 last poll match", {got_done, got_err}, 2'b10);
    chk("R5 last poll cycle", n_end, 8 + MXP * IV);

    // R8 start while busy
    do_reset();
    run_seq(1, 16'h0400, 16'h0400, 0, 1);
    chk("R8 timing", n_end, 8 + IV);
    chk("R8 done", got_done, 1'b1);

    // R7 resets cleared by next start, err cleared by next start
    run_seq(1, 16'h1234, 16'h1234, 0, 0);
    chk("R7 resets cleared", {r1_aon, r1_sys}, 2'b00);
    chk("R7 err after timeout", got_err, 1'b1);
    chk("R5 cfg from prior", cfg, C_CTL);
    run_seq(1, 16'h0400, 16'h0400, 0, 0);
    chk("R7 err cleared", r1_err, 1'b0);
    chk("R7 rerun done", {got_done, n_end}, {1'b1, 32'(8 + IV)});

    finish_run();
  end
endmodule